// File: doc/BRIEF.md
# Receive Buffer Pool Selector

Once a received frame's byte length is known, this block chooses which of four receive buffer pools the receive DMA channel should fill. Each pool supplies three inputs: a channel-enable bit, a buffer-available flag and a buffer size in bytes. The pools are numbered 0 to 3. The block visits them in that fixed order and takes the first one that fits. It gives up at once if it reaches a pool whose channel is disabled.

A request enters through a valid/ready handshake that carries the frame length. While a search is running, `req_ready` is low. A request offered during that time is simply not taken: the block has no queue, so the requester must keep `req_valid` high until the transfer completes. The block checks one pool per clock. When the search ends, it raises `done` for a single cycle and presents either the chosen pool index or a no-buffer error. The results have no back-pressure, because the block never waits for its consumer. The pool configuration inputs are read live while the search runs, so the consumer must hold them steady until `done`.

Top module: `rx_pool_select`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), `done` = 0, `no_buf` = 0, `sel_idx` = 0 and `req_ready` = 1.
- R2: A request is accepted at a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the cycle after acceptance up to the cycle before `done`. It is 1 again in the `done` cycle.
- R3: Pools are examined in index order 0, 1, 2, 3, one per clock. When the search stops at pool i, `done` is high in the (i+2)-th cycle after the acceptance cycle.
- R4: The search stops at the lowest-indexed pool that has enable = 1, available = 1 and a fitting size. In that case `no_buf` = 0 and `sel_idx` holds that pool's index. An unavailable pool that is enabled is skipped.
- R5: A pool fits when its size is greater than or equal to the frame length. An equal size fits, including the largest 11-bit length (2047).
- R6: Reaching a pool whose enable bit is 0 ends the search at that pool with `no_buf` = 1. Later pools are not considered, even if they would fit.
- R7: If all four pools are enabled and none fits, the search ends after pool 3 with `no_buf` = 1.
- R8: `done` stays high for exactly one cycle per search. `sel_idx` and `no_buf` hold their values until the next `done`. `sel_idx` is 0 whenever `no_buf` = 1.
- R9: A `req_valid` seen while a search is in progress is not accepted. It changes neither the running search nor its result, and it creates no extra `done`.
- R10: A request held valid during the `done` cycle is accepted at the end of that cycle, so searches can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Search request valid |
| req_ready | output | 1 | Block is idle and can take a request |
| req_len | input | 11 | Frame length in bytes |
| pool_en | input | 4 | Channel-enable bit per pool (bit i = pool i) |
| pool_avail | input | 4 | Buffer-available flag per pool |
| pool_size | input | 48 | Buffer sizes, pool i at bits [12*i +: 12] |
| done | output | 1 | One-cycle search-complete strobe |
| sel_idx | output | 2 | Chosen pool index (0 when no_buf) |
| no_buf | output | 1 | No pool could take the frame |

## Verification
The assertions check the timing rules on every cycle. `done` is never two cycles long. `done` only follows a search cycle. `req_ready` falls right after an acceptance, and a new acceptance cannot produce `done` on the next cycle. The latched length stays fixed while a search runs, and a miss always reports index 0. Whether the right pool was chosen depends on the order of visits, the equal-size boundary and the early stop at a disabled channel. Only the bench's reference model can show that, by comparing its result and latency with the design over chosen configurations. The same holds for the ignored mid-search request and the back-to-back handover.

// File: rtl/rxps_pkg.sv
package rxps_pkg;
  typedef enum logic [0:0] {
    SC_IDLE = 1'b0,
    SC_SCAN = 1'b1
  } scan_state_e;

  typedef enum logic [1:0] {
    EV_NEXT = 2'd0,
    EV_HIT  = 2'd1,
    EV_STOP = 2'd2
  } pool_verdict_e;
endpackage

// File: rtl/rxps_fit_eval.sv
module rxps_fit_eval
  import rxps_pkg::*;
#(
  parameter int NUM_POOLS = 4,
  parameter int LEN_W     = 11,
  parameter int SIZE_W    = 12,
  localparam int IDX_W    = $clog2(NUM_POOLS),
  localparam int CMP_W    = (LEN_W > SIZE_W) ? LEN_W : SIZE_W
) (
  input  logic [NUM_POOLS-1:0]        pool_en,
  input  logic [NUM_POOLS-1:0]        pool_avail,
  input  logic [NUM_POOLS*SIZE_W-1:0] pool_size,
  input  logic [LEN_W-1:0]            len_q,
  input  logic [IDX_W-1:0]            idx,
  output pool_verdict_e               verdict
);
  logic [NUM_POOLS-1:0] fits;
  logic [CMP_W-1:0]     len_ext;

  assign len_ext = CMP_W'(len_q);

  // one size comparator per pool
  for (genvar p = 0; p < NUM_POOLS; p++) begin : g_pool
    logic [CMP_W-1:0] size_ext;
    assign size_ext = CMP_W'(pool_size[p*SIZE_W +: SIZE_W]);
    assign fits[p]  = pool_avail[p] && (size_ext >= len_ext);
  end

  always_comb begin
    if (!pool_en[idx])   verdict = EV_STOP;
    else if (fits[idx])  verdict = EV_HIT;
    else                 verdict = EV_NEXT;
  end
endmodule

// File: rtl/rxps_scan_ctrl.sv
module rxps_scan_ctrl
  import rxps_pkg::*;
#(
  parameter int NUM_POOLS = 4,
  parameter int LEN_W     = 11,
  localparam int IDX_W    = $clog2(NUM_POOLS),
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_POOLS - 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [LEN_W-1:0] req_len,
  input  pool_verdict_e    verdict,
  output logic             req_ready,
  output logic             busy,
  output logic [IDX_W-1:0] idx,
  output logic [LEN_W-1:0] len_q,
  output logic             finish,
  output logic             finish_miss
);
  scan_state_e state;

  assign busy        = (state == SC_SCAN);
  assign req_ready   = (state == SC_IDLE);
  assign finish      = busy && ((verdict != EV_NEXT) || (idx == LAST_IDX));
  assign finish_miss = (verdict != EV_HIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= SC_IDLE;
      idx   <= '0;
      len_q <= '0;
    end else begin
      unique case (state)
        SC_IDLE: if (req_valid) begin
          state <= SC_SCAN;
          idx   <= '0;
          len_q <= req_len;
        end
        SC_SCAN: begin
          if (finish) state <= SC_IDLE;
          else        idx   <= idx + 1'b1;
        end
        default: state <= SC_IDLE;
      endcase
    end
  end

  // R9: the length under search never moves mid-search
  a_r9_len_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(len_q));

  // R3: an accepted request cannot finish in the very next cycle's edge
  a_r3_no_zero_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
endmodule

// File: rtl/rxps_result_reg.sv
module rxps_result_reg #(
  parameter int NUM_POOLS = 4,
  localparam int IDX_W    = $clog2(NUM_POOLS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             finish,
  input  logic             finish_miss,
  input  logic             busy,
  input  logic [IDX_W-1:0] idx,
  output logic             done,
  output logic [IDX_W-1:0] sel_idx,
  output logic             no_buf
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done    <= 1'b0;
      sel_idx <= '0;
      no_buf  <= 1'b0;
    end else begin
      done <= finish;
      if (finish) begin
        no_buf  <= finish_miss;
        sel_idx <= finish_miss ? '0 : idx;
      end
    end
  end

  // R8: strobe lasts a single cycle
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3: a result only follows a cycle in which a pool was examined
  a_r3_done_after_scan: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));
endmodule

// File: rtl/rx_pool_select.sv
module rx_pool_select #(
  parameter int NUM_POOLS = 4,
  parameter int LEN_W     = 11,
  parameter int SIZE_W    = 12,
  localparam int IDX_W    = $clog2(NUM_POOLS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic [LEN_W-1:0]            req_len,
  input  logic [NUM_POOLS-1:0]        pool_en,
  input  logic [NUM_POOLS-1:0]        pool_avail,
  input  logic [NUM_POOLS*SIZE_W-1:0] pool_size,
  output logic                        done,
  output logic [IDX_W-1:0]            sel_idx,
  output logic                        no_buf
);
  import rxps_pkg::*;

  pool_verdict_e    verdict;
  logic             busy;
  logic [IDX_W-1:0] idx;
  logic [LEN_W-1:0] len_q;
  logic             finish;
  logic             finish_miss;

  rxps_fit_eval #(
    .NUM_POOLS(NUM_POOLS), .LEN_W(LEN_W), .SIZE_W(SIZE_W)
  ) u_eval (
    .pool_en(pool_en), .pool_avail(pool_avail), .pool_size(pool_size),
    .len_q(len_q), .idx(idx), .verdict(verdict)
  );

  rxps_scan_ctrl #(
    .NUM_POOLS(NUM_POOLS), .LEN_W(LEN_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_len(req_len),
    .verdict(verdict), .req_ready(req_ready), .busy(busy), .idx(idx),
    .len_q(len_q), .finish(finish), .finish_miss(finish_miss)
  );

  rxps_result_reg #(
    .NUM_POOLS(NUM_POOLS)
  ) u_res (
    .clk(clk), .rst_n(rst_n), .finish(finish), .finish_miss(finish_miss),
    .busy(busy), .idx(idx), .done(done), .sel_idx(sel_idx), .no_buf(no_buf)
  );

  // R8: a miss never carries an index
  a_r8_miss_index_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (done && no_buf) |-> (sel_idx == '0));

  // R2: ready drops right after a handshake
  a_r2_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!req_ready && !done));
endmodule

// File: tb/rx_pool_select_tb.sv
module rx_pool_select_tb_top;
  localparam int NP = 4;
  localparam int LW = 11;
  localparam int SW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [LW-1:0] req_len = '0;
  logic [NP-1:0] pool_en = '1;
  logic [NP-1:0] pool_avail = '1;
  logic [NP*SW-1:0] pool_size = '0;
  logic          done;
  logic [1:0]    sel_idx;
  logic          no_buf;

  int n_checks = 0;
  int n_errs   = 0;
  int cyc      = 0;

  always #2.5 clk = ~clk;

  rx_pool_select #(.NUM_POOLS(NP), .LEN_W(LW), .SIZE_W(SW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_len(req_len), .pool_en(pool_en), .pool_avail(pool_avail),
    .pool_size(pool_size), .done(done), .sel_idx(sel_idx), .no_buf(no_buf)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit m_busy = 0, m_done = 0, m_nb = 0;
  int m_sel = 0, m_left = 0, m_res_sel = 0, m_stop = 0;
  bit m_res_nb = 0;

  task automatic ref_search(input int len, output int sel, output bit nb, output int stop);
    sel = 0; nb = 1; stop = NP - 1;
    for (int i = 0; i < NP; i++) begin
      if (!pool_en[i]) begin stop = i; return; end
      if (pool_avail[i] && int'(pool_size[i*SW +: SW]) >= len) begin
        sel = i; nb = 0; stop = i; return;
      end
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_nb = 0; m_sel = 0; m_left = 0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_left--;
        if (m_left == 0) begin
          m_busy = 0; m_done = 1; m_sel = m_res_sel; m_nb = m_res_nb;
        end
      end else if (req_valid) begin
        ref_search(int'(req_len), m_res_sel, m_res_nb, m_stop);
        m_busy = 1; m_left = m_stop + 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(req_ready == !m_busy, "R2 req_ready", req_ready, !m_busy);
      chk(done == m_done, "R3 done timing", done, m_done);
      chk(int'(sel_idx) == m_sel, "R4 sel_idx", sel_idx, m_sel);
      chk(no_buf == m_nb, "R6 no_buf", no_buf, m_nb);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic set_sizes(input int s0, input int s1, input int s2, input int s3);
    pool_size = {SW'(s3), SW'(s2), SW'(s1), SW'(s0)};
  endtask

  task automatic run_req(input int len, input int e_sel, input bit e_nb,
                         input int e_lat, input string tag);
    int n;
    @(posedge clk); #1;
    req_valid = 1; req_len = LW'(len);
    @(posedge clk); #1;
    req_valid = 0;
    n = 1;
    for (int k = 0; k < 20; k++) begin
      @(posedge clk); #1;
      n++;
      if (done) break;
    end
    chk(n == e_lat, {tag, " latency"}, n, e_lat);
    chk(int'(sel_idx) == e_sel, {tag, " index"}, sel_idx, e_sel);
    chk(no_buf == e_nb, {tag, " no_buf"}, no_buf, e_nb);
    @(posedge clk); #1;
    chk(done == 0, "R8 strobe one cycle", done, 0);
    chk(int'(sel_idx) == e_sel, "R8 index held", sel_idx, e_sel);
  endtask

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_errs++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
      $finish;
    end
  end

  initial begin
    int dcount;
    set_sizes(100, 200, 300, 400);
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #1;
    // R1 reset values
    chk(done == 0, "R1 done", done, 0);
    chk(no_buf == 0, "R1 no_buf", no_buf, 0);
    chk(sel_idx == 0, "R1 sel_idx", sel_idx, 0);
    chk(req_ready == 1, "R1 req_ready", req_ready, 1);

    // R4 / R3 first fit in order
    run_req(150, 1, 0, 3, "R4 first fit pool1");
    run_req(50, 0, 0, 2, "R3 pool0 latency");
    // R5 equal size fits
    run_req(200, 1, 0, 3, "R5 equal size");
    run_req(201, 2, 0, 4, "R5 one above");
    // R7 nothing fits
    run_req(500, 0, 1, 5, "R7 none fits");
    // R4 unavailable pool skipped
    @(posedge clk); #1 pool_avail = 4'b1110;
    run_req(50, 1, 0, 3, "R4 skip unavailable");
    pool_avail = 4'b1111;
    // R6 disabled pool stops search although pool3 fits
    pool_en = 4'b1011;
    run_req(350, 0, 1, 4, "R6 stop at disabled pool2");
    pool_en = 4'b1110;
    run_req(10, 0, 1, 2, "R6 stop at disabled pool0");
    pool_en = 4'b1111;
    // R5 max length
    set_sizes(10, 10, 10, 2047);
    run_req(2047, 3, 0, 5, "R5 max length");

    // R9 request during busy ignored
    set_sizes(100, 200, 300, 400);
    dcount = 0;
    @(posedge clk); #1 req_valid = 1; req_len = LW'(350);
    @(posedge clk); #1 req_valid = 1; req_len = LW'(5);
    chk(req_ready == 0, "R9 busy not ready", req_ready, 0);
    @(posedge clk); #1 req_valid = 0;
    for (int k = 0; k < 10; k++) begin
      if (done) begin
        dcount++;
        chk(int'(sel_idx) == 3, "R9 result unchanged", sel_idx, 3);
      end
      @(posedge clk); #1;
    end
    chk(dcount == 1, "R9 single done", dcount, 1);

    // R10 back to back: second request held through done cycle
    @(posedge clk); #1 req_valid = 1; req_len = LW'(250);
    for (int k = 0; k < 20; k++) begin
      @(posedge clk); #1;
      if (done) break;
    end
    chk(int'(sel_idx) == 2, "R10 first result", sel_idx, 2);
    req_len = LW'(20);
    chk(req_ready == 1, "R10 ready in done cycle", req_ready, 1);
    @(posedge clk); #1 req_valid = 0;
    chk(req_ready == 0, "R10 second accepted", req_ready, 0);
    @(posedge clk); #1;
    chk(done == 1 && sel_idx == 0, "R10 second result", sel_idx, 0);

    repeat (5) @(posedge clk);
    #1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end
endmodule